// File: doc/BRIEF.md
# UART interrupt priority identifier

This block merges the interrupt causes of a FIFO-equipped UART into a single interrupt request and a 4-bit identification code that software reads to learn what needs service. Five causes are tracked: receive errors, receive data ready, receive character time-out, transmit holding space empty, and modem line change. Each cause is cleared by the register access that services it. The block reports only the most urgent visible cause.

The receive and transmit datapaths feed it FIFO fill levels, push strobes, error and modem-change pulses, and a bit-rate tick. The bus decoder feeds it one-cycle strobes for reads of the identification, line status, receive buffer and modem status registers, and for writes to the transmit holding register. Both the code and the interrupt line are registered. A read of the identification register therefore acts on the code that is already on the output at that clock edge.

The transmit-empty cause has a deferred start. If the transmit FIFO did not hold two or more characters since the last time it went empty, the cause waits about one character time before it asserts. This gives software room to refill the FIFO without first taking an interrupt.

Top module: `uart_irq_ident`

## Requirements
- R1: With nothing visible pending, `iir_code` is 4'b0001 and `irq` is 0. When any cause is reported, bit 0 of `iir_code` is 0 and `irq` is 1. Both outputs come from the same clock edge.
- R2: Reporting order, most urgent first: receive error 4'b0110, then receive data 4'b0100, then character time-out 4'b1100, then transmit empty 4'b0010, then modem change 4'b0000. Receive data beats time-out at the shared second level.
- R3: Any bit of `rx_err` (overrun, parity, framing, break) latches the receive-error cause, and `lsr_rd` clears it. A new error in the same cycle as `lsr_rd` keeps the cause set.
- R4: Receive data is pending while `rx_level` is nonzero. When `fifo_en` is 1, it also needs `rx_level >= rx_trig`. It drops by itself once the level falls below that condition.
- R5: Character time-out is pending when `rx_level` is nonzero and 4*`frame_bits` `bit_tick` pulses pass with no `rx_push` and no `rbr_rd`. Either strobe restarts the count and removes the time-out.
- R6: When `tx_level` reaches 0 and had been 2 or more at some point since the previous empty event, transmit empty is raised on that edge, with no delay.
- R7: Otherwise, including the first empty state after reset, transmit empty is raised only after `frame_bits`-1 `bit_tick` pulses.
- R8: `thr_wr` clears transmit empty. `iir_rd` clears it only when `iir_code` is 4'b0010 at that clock edge. A read while another code is shown leaves it pending.
- R9: Any bit of `modem_chg` latches the modem cause, and `msr_rd` clears it.
- R10: Enable bits in `ien`: bit 0 covers receive data and time-out, bit 1 transmit empty, bit 2 receive error, bit 3 modem. A cleared bit keeps its cause out of `iir_code` and `irq`. The cause stays latched and shows once the bit is set again.
- R11: `iir_code` only ever takes the values 0001, 0110, 0100, 1100, 0010 or 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien | input | 4 | Per-cause enables (see R10) |
| fifo_en | input | 1 | FIFO mode: receive data uses the trigger level |
| rx_trig | input | LVL_W | Receive trigger level |
| frame_bits | input | FB_W | Bits per character frame, including start and stop bits |
| bit_tick | input | 1 | One pulse per bit time |
| rx_err | input | 4 | Receive error pulses: overrun, parity, framing, break |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | A character entered the receive FIFO |
| rbr_rd | input | 1 | Receive buffer read strobe |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| modem_chg | input | 4 | Modem line change pulses: CTS, DSR, RI, DCD |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_code | output | 4 | Identification code of the reported cause |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets the transmit-empty qualification. It checks the immediate raise after a two-deep fill, the deferred raise after a single-character fill and after reset, and an identification read taken while a receive error is shown. A design that cleared transmit empty on any identification read would lose that interrupt. A design that skipped the deferral would raise it right after reset.

It also checks the time-out window on both sides of 4*`frame_bits` ticks. It confirms that receive data beats a time-out that is also pending. It checks that a line-status read in the same cycle as a new error keeps the cause set; a clear-first design would drop that error.

Random fill levels, trigger values and FIFO modes exercise the data-ready rule in both modes.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  localparam logic [3:0] CODE_NONE = 4'b0001;
  localparam logic [3:0] CODE_RLS  = 4'b0110;
  localparam logic [3:0] CODE_RDA  = 4'b0100;
  localparam logic [3:0] CODE_CTI  = 4'b1100;
  localparam logic [3:0] CODE_THRE = 4'b0010;
  localparam logic [3:0] CODE_MS   = 4'b0000;

  localparam int IEN_RX   = 0;
  localparam int IEN_THRE = 1;
  localparam int IEN_RLS  = 2;
  localparam int IEN_MS   = 3;

  // Bit ticks of silence before a receive time-out: four frames.
  function automatic int unsigned cti_limit(input int unsigned fbits);
    return fbits * 4;
  endfunction

  // Deferred start of transmit empty: one frame less the stop bit.
  function automatic int unsigned thre_wait(input int unsigned fbits);
    return (fbits > 1) ? fbits - 1 : 1;
  endfunction

  function automatic logic rda_hit(input logic fe, input int unsigned lvl,
                                   input int unsigned trig);
    if (lvl == 0) return 1'b0;
    if (!fe) return 1'b1;
    return lvl >= trig;
  endfunction

  function automatic logic code_legal(input logic [3:0] c);
    return (c == CODE_NONE) || (c == CODE_RLS) || (c == CODE_RDA) ||
           (c == CODE_CTI) || (c == CODE_THRE) || (c == CODE_MS);
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
`timescale 1ns/1ps
module uart_irq_sticky #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_vec,
  input  logic             clr,
  output logic             flag
);

  logic set_any;
  assign set_any = |set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_any) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  // R3 / R9: a new event is never lost to a same-cycle clear
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> flag);
  // R3 / R9: a clear with no new event drops the cause
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_any) |=> !flag);

endmodule

// File: rtl/uart_irq_rx.sv
`timescale 1ns/1ps
module uart_irq_rx
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int FB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic             bit_tick,
  input  logic [FB_W-1:0]  frame_bits,
  output logic             rda_req,
  output logic             cti_req
);

  localparam int CNT_W = FB_W + 3;

  logic [CNT_W-1:0] idle_cnt;
  logic [CNT_W-1:0] idle_lim;
  logic             rx_activity;
  logic             rx_empty;

  assign idle_lim    = CNT_W'(cti_limit(32'(frame_bits)));
  assign rx_activity = rx_push | rbr_rd;
  assign rx_empty    = (rx_level == '0);
  assign rda_req     = rda_hit(fifo_en, 32'(rx_level), 32'(rx_trig));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         idle_cnt <= '0;
    else if (rx_activity || rx_empty)   idle_cnt <= '0;
    else if (bit_tick && idle_cnt != idle_lim) idle_cnt <= idle_cnt + 1'b1;
  end

  assign cti_req = !rx_empty && (idle_cnt == idle_lim);

  // R5: activity restarts the silence window
  a_r5_activity_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_activity && frame_bits != '0 && $stable(frame_bits)) |=>
      (!cti_req || frame_bits != $past(frame_bits)));

endmodule

// File: rtl/uart_irq_thre.sv
`timescale 1ns/1ps
module uart_irq_thre
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int FB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic [3:0]       code_now,
  input  logic             bit_tick,
  input  logic [FB_W-1:0]  frame_bits,
  output logic             thre_req
);

  localparam int CNT_W = FB_W + 1;

  logic             tx_empty;
  logic             empty_q;
  logic             empty_evt;
  logic             seen_two;
  logic             iir_clr;
  logic             dly_run;
  logic [CNT_W-1:0] dly_cnt;
  logic [CNT_W-1:0] dly_len;
  logic             dly_done;

  assign tx_empty  = (tx_level == '0);
  assign empty_evt = tx_empty && !empty_q;
  assign iir_clr   = iir_rd && (code_now == CODE_THRE);
  assign dly_len   = CNT_W'(thre_wait(32'(frame_bits)));
  assign dly_done  = dly_run && bit_tick && ((dly_cnt + 1'b1) >= dly_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q  <= 1'b1;
      seen_two <= 1'b0;
    end else begin
      empty_q <= tx_empty;
      if (empty_evt)                    seen_two <= 1'b0;
      else if (tx_level >= LVL_W'(2))   seen_two <= 1'b1;
    end
  end

  // Reset counts as an empty event without a two-deep fill: start deferred.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_req <= 1'b0;
      dly_run  <= 1'b1;
      dly_cnt  <= '0;
    end else if (thr_wr) begin
      thre_req <= 1'b0;
      dly_run  <= 1'b0;
    end else if (empty_evt) begin
      if (seen_two) thre_req <= 1'b1;
      else begin
        dly_run <= 1'b1;
        dly_cnt <= '0;
      end
    end else if (iir_clr) begin
      thre_req <= 1'b0;
    end else if (dly_done) begin
      thre_req <= 1'b1;
      dly_run  <= 1'b0;
    end else if (dly_run && bit_tick) begin
      dly_cnt <= dly_cnt + 1'b1;
    end
  end

  // R6: a two-deep fill gives an immediate raise on the empty edge
  a_r6_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_evt && seen_two && !thr_wr) |=> thre_req);
  // R7: without a two-deep fill nothing is raised on the empty edge
  a_r7_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_evt && !seen_two && !thr_wr && !thre_req) |=> !thre_req);
  // R8: a holding register write clears the cause
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_req);
  // R8: a read while another code is shown keeps the cause
  a_r8_read_other: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && code_now != CODE_THRE && thre_req && !thr_wr) |=> thre_req);

endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ien,
  input  logic       rls_req,
  input  logic       rda_req,
  input  logic       cti_req,
  input  logic       thre_req,
  input  logic       ms_req,
  output logic [3:0] code_q,
  output logic       irq_q
);

  logic       vis_rls, vis_rda, vis_cti, vis_thre, vis_ms;
  logic [3:0] code_nxt;

  assign vis_rls  = rls_req  && ien[IEN_RLS];
  assign vis_rda  = rda_req  && ien[IEN_RX];
  assign vis_cti  = cti_req  && ien[IEN_RX];
  assign vis_thre = thre_req && ien[IEN_THRE];
  assign vis_ms   = ms_req   && ien[IEN_MS];

  always_comb begin
    if (vis_rls)       code_nxt = CODE_RLS;
    else if (vis_rda)  code_nxt = CODE_RDA;
    else if (vis_cti)  code_nxt = CODE_CTI;
    else if (vis_thre) code_nxt = CODE_THRE;
    else if (vis_ms)   code_nxt = CODE_MS;
    else               code_nxt = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_NONE;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_nxt;
      irq_q  <= !code_nxt[0];
    end
  end

  // R11: only defined codes appear
  a_r11_legal: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal(code_q));
  // R2: a visible receive error always wins
  a_r2_rls_top: assert property (@(posedge clk) disable iff (!rst_n)
    vis_rls |=> (code_q == CODE_RLS));
  // R2: receive data beats time-out at the shared level
  a_r2_rda_over_cti: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_rda && !vis_rls) |=> (code_q == CODE_RDA));
  // R10: a masked modem cause never shows
  a_r10_ms_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ien[IEN_MS] |=> (code_q != CODE_MS));
  // R1: a raised line always goes with a reported cause
  a_r1_line_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_req && ien[IEN_MS]) |=> irq_q);

endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident #(
  parameter int LVL_W = 5,
  parameter int FB_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ien,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [FB_W-1:0]  frame_bits,
  input  logic             bit_tick,
  input  logic [3:0]       rx_err,
  input  logic             lsr_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic [3:0]       modem_chg,
  input  logic             msr_rd,
  output logic [3:0]       iir_code,
  output logic             irq
);

  logic rls_req, rda_req, cti_req, thre_req, ms_req;

  uart_irq_sticky #(.N_SRC(4)) u_rls (
    .clk(clk), .rst_n(rst_n), .set_vec(rx_err), .clr(lsr_rd), .flag(rls_req));

  uart_irq_sticky #(.N_SRC(4)) u_ms (
    .clk(clk), .rst_n(rst_n), .set_vec(modem_chg), .clr(msr_rd), .flag(ms_req));

  uart_irq_rx #(.LVL_W(LVL_W), .FB_W(FB_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_level(rx_level),
    .rx_trig(rx_trig), .rx_push(rx_push), .rbr_rd(rbr_rd),
    .bit_tick(bit_tick), .frame_bits(frame_bits),
    .rda_req(rda_req), .cti_req(cti_req));

  uart_irq_thre #(.LVL_W(LVL_W), .FB_W(FB_W)) u_thre (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .thr_wr(thr_wr),
    .iir_rd(iir_rd), .code_now(iir_code), .bit_tick(bit_tick),
    .frame_bits(frame_bits), .thre_req(thre_req));

  uart_irq_prio u_prio (
    .clk(clk), .rst_n(rst_n), .ien(ien), .rls_req(rls_req),
    .rda_req(rda_req), .cti_req(cti_req), .thre_req(thre_req),
    .ms_req(ms_req), .code_q(iir_code), .irq_q(irq));

endmodule

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;

  localparam int LVL_W = 5;
  localparam int FB_W  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       ien = 4'b1111;
  logic             fifo_en = 1'b1;
  logic [LVL_W-1:0] rx_trig = 5'd4;
  logic [FB_W-1:0]  frame_bits = 4'd10;
  logic             bit_tick = 1'b0;
  logic [3:0]       rx_err = '0;
  logic             lsr_rd = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic             rx_push = 1'b0;
  logic             rbr_rd = 1'b0;
  logic [LVL_W-1:0] tx_level = '0;
  logic             thr_wr = 1'b0;
  logic             iir_rd = 1'b0;
  logic [3:0]       modem_chg = '0;
  logic             msr_rd = 1'b0;
  logic [3:0]       iir_code;
  logic             irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  uart_irq_ident #(.LVL_W(LVL_W), .FB_W(FB_W)) dut (
    .clk(clk), .rst_n(rst_n), .ien(ien), .fifo_en(fifo_en),
    .rx_trig(rx_trig), .frame_bits(frame_bits), .bit_tick(bit_tick),
    .rx_err(rx_err), .lsr_rd(lsr_rd), .rx_level(rx_level),
    .rx_push(rx_push), .rbr_rd(rbr_rd), .tx_level(tx_level),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .modem_chg(modem_chg),
    .msr_rd(msr_rd), .iir_code(iir_code), .irq(irq));

  // Expected code from the requirement table, written as a scan over levels.
  function automatic logic [3:0] want_code(input logic e, input logic d,
      input logic t, input logic h, input logic m);
    logic [3:0] c;
    c = 4'b0001;
    if (m) c = 4'b0000;
    if (h) c = 4'b0010;
    if (t) c = 4'b1100;
    if (d) c = 4'b0100;
    if (e) c = 4'b0110;
    return c;
  endfunction

  function automatic logic want_rda(input logic fe, input int lvl, input int trig);
    if (fe) return (lvl > 0) && !(lvl < trig);
    return lvl != 0;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if (iir_code !== exp) begin
      fails++;
      $display("FAIL %s code got %b expected %b", tag, iir_code, exp);
    end
    checks++;
    if (irq !== !exp[0]) begin
      fails++;
      $display("FAIL %s irq got %b expected %b", tag, irq, !exp[0]);
    end
  endtask

  task automatic p_iir; iir_rd = 1; step(1); iir_rd = 0; endtask
  task automatic p_lsr; lsr_rd = 1; step(1); lsr_rd = 0; endtask
  task automatic p_msr; msr_rd = 1; step(1); msr_rd = 0; endtask
  task automatic fill_tx(input int n);
    tx_level = LVL_W'(n); thr_wr = 1; step(1); thr_wr = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(20240611);
    step(3);
    rst_n = 1'b1;
    chk("R1 reset", 4'b0001);

    // R7: deferred start after reset
    bit_tick = 1; step(5);
    chk("R7 startup not yet", 4'b0001);
    step(10);
    chk("R7 startup raised", 4'b0010);
    bit_tick = 0;

    // R8: read while shown clears
    p_iir(); step(2);
    chk("R8 iir read clears", 4'b0001);

    // R6: two-deep fill then empty raises at once
    fill_tx(3); step(1); tx_level = '0; step(2);
    chk("R6 immediate", 4'b0010);

    // R8: write clears; R7: single fill defers
    fill_tx(1); step(2);
    chk("R8 write clears", 4'b0001);
    tx_level = '0; step(20);
    chk("R7 single fill waits", 4'b0001);
    bit_tick = 1; step(15); bit_tick = 0;
    chk("R7 single fill raised", 4'b0010);

    // R3 and R8: read while an error is shown keeps transmit empty
    rx_err = 4'b0100; step(1); rx_err = '0; step(2);
    chk("R3 error latched", 4'b0110);
    p_iir(); step(2);
    chk("R8 read under error", 4'b0110);
    p_lsr(); step(2);
    chk("R8 thre survived", 4'b0010);
    p_iir(); step(2);
    chk("R8 cleared after shown", 4'b0001);

    // R3: new error in same cycle as a clear read
    rx_err = 4'b0001; lsr_rd = 1; step(1); rx_err = '0; lsr_rd = 0; step(2);
    chk("R3 set wins", 4'b0110);
    p_lsr(); step(2);
    chk("R3 cleared", 4'b0001);

    // R9 and R1: modem code 0000 drives the line
    modem_chg = 4'b0010; step(1); modem_chg = '0; step(2);
    chk("R9 modem raised", 4'b0000);
    p_msr(); step(2);
    chk("R9 modem cleared", 4'b0001);

    // R10: masking
    ien[3] = 0;
    modem_chg = 4'b1000; step(1); modem_chg = '0; step(2);
    chk("R10 modem masked", 4'b0001);
    ien[3] = 1; step(2);
    chk("R10 modem unmasked", 4'b0000);

    // R2: stacked causes unwind in order
    fill_tx(2); step(1); tx_level = '0; step(1);
    rx_err = 4'b1000; rx_level = 5'd5; rx_push = 1; step(1);
    rx_err = '0; rx_push = 0; step(2);
    chk("R2 error first", 4'b0110);
    p_lsr(); step(2);
    chk("R2 data second", 4'b0100);
    rx_level = '0; step(2);
    chk("R4 data drops below", 4'b0010);
    p_iir(); step(2);
    chk("R2 modem last", 4'b0000);
    p_msr(); step(2);
    chk("R2 all clear", 4'b0001);

    // R5: time-out window of 4*frame_bits ticks
    rx_level = 5'd1; rx_push = 1; step(1); rx_push = 0;
    bit_tick = 1; step(30);
    chk("R5 not yet", 4'b0001);
    step(15);
    chk("R5 time-out", 4'b1100);
    rbr_rd = 1; step(1); rbr_rd = 0; step(2);
    chk("R5 read restarts", 4'b0001);
    rx_level = 5'd5; step(45);
    chk("R5 data beats time-out", 4'b0100);
    bit_tick = 0; rx_level = '0; step(2);
    chk("R4 empty", 4'b0001);

    // R4 / R3 random: levels, triggers, modes
    fill_tx(1);
    for (int i = 0; i < 60; i++) begin
      int lvl, trg;
      logic fe, er;
      lvl = int'($urandom % 17);
      trg = 1 + int'($urandom % 15);
      fe  = 1'($urandom % 2);
      er  = ($urandom % 4) == 0;
      rx_level = LVL_W'(lvl); rx_trig = LVL_W'(trg); fifo_en = fe;
      rx_push = 1; rx_err = er ? 4'b0010 : 4'b0000;
      step(1);
      rx_push = 0; rx_err = '0;
      step(2);
      chk($sformatf("R4 rand lvl=%0d trig=%0d fe=%0d err=%0d", lvl, trg, fe, er),
          want_code(er, want_rda(fe, lvl, trg), 1'b0, 1'b0, 1'b0));
      if (er) begin p_lsr(); step(1); end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule